// File: doc/BRIEF.md
# Emulated Configuration-Space Responder

This block answers PCI configuration cycles for on-chip functions that have no real configuration header. Each request carries a bus number, a device/function number, a byte offset, an access size in bytes and write data. Requests to the emulated slots are served from constant header tables held inside the block. Requests to anything else are passed, field for field and in the same cycle, to a pass-through configuration port, and the data that port returns becomes the read response.

The headers are read-only, so writes to emulated functions are dropped. Software sizes a base address register by writing all ones to it and reading it back. The block supports this without storing any register value. It records that an all-ones write landed in the BAR window, and answers the next emulated read in that window from a size-mask area placed ahead of the header data in each table. A variant-select input picks between two table sets for two of the functions, and enables one function that exists only in the second set.

Every read gets a one-cycle registered response. Writes that software is not expected to make raise a one-cycle warning pulse.

Top module: `cfg_emu_responder`

## Requirements
- R1: A request is emulated when its bus is 0 and device/function bits [7:3] (the device number) equal 1 or 15. Every other request drives fwd_valid in the same cycle, with bus, device/function, offset, size, write flag and write data unchanged. A forwarded read responds one cycle later with the fwd_rdata value sampled in the request cycle and rsp_err low. Emulated requests keep fwd_valid low.
- R2: rsp_valid is high for exactly the one cycle after each read request (req_write=0). A write produces no response.
- R3: An emulated read at offset r below 0x70 returns table dword 8 + r/4, which is the header data 0x20 bytes into the table. That dword is shifted right by 8*(r mod 4) and masked to the size: 1 gives 8 bits, 2 gives 16, 4 gives 32. Bytes past the end of the dword read as zero.
- R4: A write of 32'hFFFFFFFF to an emulated function at an offset from 0x10 to 0x2B sets a probe flag. While the flag is set, the next emulated read with its offset in that window returns mask dword (r-0x10)/4 from the start of the table.
- R5: Every emulated read clears the probe flag. An emulated read outside the window while the flag is set returns normal header data. Forwarded accesses neither set nor clear the flag.
- R6: An emulated read at offset 0x70 or above returns zero, even for an unknown function.
- R7: An emulated read of a device/function with no table returns 32'hFFFFFFFF. The tables exist for 0x08, 0x09, 0x0A, 0x78 and 0x7C.
- R8: With variant_sel=0, functions 0x08 and 0x09 use table set A, and 0x0A has no table. With variant_sel=1 they use set B, and 0x0A is present.
- R9: Writes to emulated functions are discarded. A later read returns the table value. A write of any value other than all ones leaves the probe flag unchanged.
- R10: warn_pulse is high for the one cycle after an emulated write whose offset lies outside 0x10..0x2B and is none of 0x04, 0x0C, 0x0D, 0x30 or 0x44. All other writes keep it low.
- R11: An emulated read with a size other than 1, 2 or 4 returns 32'hFFFFFFFF with rsp_err high. Every other response has rsp_err low.
- R12: During and just after reset, rsp_valid, rsp_err and warn_pulse are low and the probe flag is clear.
- R13: The table words the bench relies on are listed here. Function 0x08: set A data at offset 0x00 is 32'h11001D0E and at 0x10 is 32'h0000C001; set B data at 0x00 is 32'h12001D0E. Function 0x09: set A mask at 0x10 is 32'hFF800008 and data at 0x00 is 32'h21001D0E; set B mask at 0x10 is 32'hFF000008 and data at 0x00 is 32'h22001D0E. Function 0x0A: data at 0x00 is 32'h23001D0E. Function 0x78: data at 0x00 is 32'h31001D0E and at 0x14 is 32'h00001001; mask at 0x14 is 32'hFFFFFF01. Function 0x7C: data at 0x40 is 32'hC8020001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device (bits 7:3) and function (bits 2:0) |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4 valid) |
| req_wdata | input | 32 | Write data |
| variant_sel | input | 1 | Table set select (0 = A, 1 = B) |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| rsp_err | output | 1 | Invalid access size on an emulated read |
| warn_pulse | output | 1 | Unexpected emulated write seen |
| fwd_valid | output | 1 | Pass-through request |
| fwd_write | output | 1 | Pass-through write flag |
| fwd_bus | output | 8 | Pass-through bus |
| fwd_devfn | output | 8 | Pass-through device/function |
| fwd_off | output | 8 | Pass-through offset |
| fwd_size | output | 3 | Pass-through size |
| fwd_wdata | output | 32 | Pass-through write data |
| fwd_rdata | input | 32 | Pass-through read data, valid in the request cycle |

## Verification
The probe flag is the only state in the block. If it is wrong, the fault shows only on the next emulated read in the BAR window, one cycle after that read is issued. A stale flag returns a mask where header data was expected, and a lost flag returns header data where a mask was expected. The bench therefore follows each probe write with reads in several orders: a read outside the window first, a forwarded read first, and a back-to-back repeat of the same read. A fault in decode or lane selection shows on the very next response, or on fwd_valid in the same cycle.

// File: rtl/cfg_emu_pkg.sv
// Shared types for the emulated configuration responder.
// Assumes a single clock domain; no state lives here.
package cfg_emu_pkg;

    // Identifies which constant header table serves a request.
    typedef enum logic [2:0] {
        FN_NONE   = 3'd0,
        FN_HOST   = 3'd1,
        FN_GFX    = 3'd2,
        FN_CRYPTO = 3'd3,
        FN_BRIDGE = 3'd4,
        FN_USB    = 3'd5
    } fn_id_e;

endpackage

// File: rtl/cfg_emu_decode.sv
// Decides whether a request targets an emulated slot and which table
// serves it. Purely combinational; assumes devfn = device*8 + function.
module cfg_emu_decode
    import cfg_emu_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int DEV_A   = 1,
    parameter int DEV_B   = 15
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic               variant,
    output logic               emu_hit,
    output fn_id_e             fn_id
);
    localparam int DEV_W = DEVFN_W - 3;
    localparam logic [DEVFN_W-1:0] DF_HOST   = DEVFN_W'(DEV_A * 8 + 0);
    localparam logic [DEVFN_W-1:0] DF_GFX    = DEVFN_W'(DEV_A * 8 + 1);
    localparam logic [DEVFN_W-1:0] DF_CRYPTO = DEVFN_W'(DEV_A * 8 + 2);
    localparam logic [DEVFN_W-1:0] DF_BRIDGE = DEVFN_W'(DEV_B * 8 + 0);
    localparam logic [DEVFN_W-1:0] DF_USB    = DEVFN_W'(DEV_B * 8 + 4);

    // Slot match: bus zero and one of the two emulated device numbers.
    always_comb begin
        emu_hit = (bus == '0) &&
                  ((devfn[DEVFN_W-1:3] == DEV_W'(DEV_A)) ||
                   (devfn[DEVFN_W-1:3] == DEV_W'(DEV_B)));
    end

    // Table pick: the crypto function is present only in variant B.
    always_comb begin
        if (devfn == DF_HOST)                  fn_id = FN_HOST;
        else if (devfn == DF_GFX)              fn_id = FN_GFX;
        else if (devfn == DF_CRYPTO && variant) fn_id = FN_CRYPTO;
        else if (devfn == DF_BRIDGE)           fn_id = FN_BRIDGE;
        else if (devfn == DF_USB)              fn_id = FN_USB;
        else                                   fn_id = FN_NONE;
    end
endmodule

// File: rtl/cfg_hdr_rom.sv
// Constant header tables. Each table holds mask dwords first, then the
// header data dwords. Words not listed read as zero. Combinational.
module cfg_hdr_rom
    import cfg_emu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  fn_id_e             fn_id,
    input  logic               variant,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  word
);
    // Table lookup: nested selection by function, variant and dword index.
    always_comb begin
        word = '0;
        unique case (fn_id)
            FN_HOST: begin
                if (!variant) begin
                    case (idx)
                        IDX_W'(0):  word = DATA_W'(32'hFFFF_FFF1);
                        IDX_W'(8):  word = DATA_W'(32'h1100_1D0E);
                        IDX_W'(9):  word = DATA_W'(32'h0220_0006);
                        IDX_W'(10): word = DATA_W'(32'h0600_0010);
                        IDX_W'(12): word = DATA_W'(32'h0000_C001);
                        IDX_W'(19): word = DATA_W'(32'h1100_1D0E);
                        default:    word = '0;
                    endcase
                end else begin
                    case (idx)
                        IDX_W'(8):  word = DATA_W'(32'h1200_1D0E);
                        IDX_W'(9):  word = DATA_W'(32'h0220_0006);
                        IDX_W'(10): word = DATA_W'(32'h0600_0010);
                        IDX_W'(19): word = DATA_W'(32'h1200_1D0E);
                        default:    word = '0;
                    endcase
                end
            end
            FN_GFX: begin
                if (!variant) begin
                    case (idx)
                        IDX_W'(0):  word = DATA_W'(32'hFF80_0008);
                        IDX_W'(1), IDX_W'(2), IDX_W'(3):
                                    word = DATA_W'(32'hFFFF_C000);
                        IDX_W'(8):  word = DATA_W'(32'h2100_1D0E);
                        IDX_W'(9):  word = DATA_W'(32'h0220_0003);
                        IDX_W'(10): word = DATA_W'(32'h0300_0000);
                        IDX_W'(12): word = DATA_W'(32'hFD00_0000);
                        IDX_W'(13): word = DATA_W'(32'hFE00_0000);
                        IDX_W'(14): word = DATA_W'(32'hFE00_4000);
                        IDX_W'(15): word = DATA_W'(32'hFE00_8000);
                        default:    word = '0;
                    endcase
                end else begin
                    case (idx)
                        IDX_W'(0):  word = DATA_W'(32'hFF00_0008);
                        IDX_W'(1), IDX_W'(2), IDX_W'(3), IDX_W'(4):
                                    word = DATA_W'(32'hFFFF_C000);
                        IDX_W'(8):  word = DATA_W'(32'h2200_1D0E);
                        IDX_W'(9):  word = DATA_W'(32'h0220_0003);
                        IDX_W'(10): word = DATA_W'(32'h0300_0000);
                        IDX_W'(12): word = DATA_W'(32'hFD00_0000);
                        IDX_W'(13): word = DATA_W'(32'hFE00_0000);
                        IDX_W'(14): word = DATA_W'(32'hFE00_4000);
                        IDX_W'(15): word = DATA_W'(32'hFE00_8000);
                        IDX_W'(16): word = DATA_W'(32'hFE00_C000);
                        IDX_W'(23): word = DATA_W'(32'h0000_010E);
                        default:    word = '0;
                    endcase
                end
            end
            FN_CRYPTO: begin
                case (idx)
                    IDX_W'(0):  word = DATA_W'(32'hFFFF_C000);
                    IDX_W'(8):  word = DATA_W'(32'h2300_1D0E);
                    IDX_W'(9):  word = DATA_W'(32'h02A0_0006);
                    IDX_W'(10): word = DATA_W'(32'h1010_0000);
                    IDX_W'(12): word = DATA_W'(32'hFE01_0000);
                    default:    word = '0;
                endcase
            end
            FN_BRIDGE: begin
                case (idx)
                    IDX_W'(0):  word = DATA_W'(32'hFFFF_FFF9);
                    IDX_W'(1):  word = DATA_W'(32'hFFFF_FF01);
                    IDX_W'(8):  word = DATA_W'(32'h3100_1D0E);
                    IDX_W'(9):  word = DATA_W'(32'h02A0_0049);
                    IDX_W'(10): word = DATA_W'(32'h0601_0003);
                    IDX_W'(12): word = DATA_W'(32'h0000_18B1);
                    IDX_W'(13): word = DATA_W'(32'h0000_1001);
                    IDX_W'(31): word = DATA_W'(32'h0000_AA5B);
                    default:    word = '0;
                endcase
            end
            FN_USB: begin
                case (idx)
                    IDX_W'(0):  word = DATA_W'(32'hFFFF_F000);
                    IDX_W'(8):  word = DATA_W'(32'h3400_1D0E);
                    IDX_W'(9):  word = DATA_W'(32'h0230_0006);
                    IDX_W'(10): word = DATA_W'(32'h0C03_1002);
                    IDX_W'(12): word = DATA_W'(32'hFE01_A000);
                    IDX_W'(21): word = DATA_W'(32'h0000_0040);
                    IDX_W'(24): word = DATA_W'(32'hC802_0001);
                    default:    word = '0;
                endcase
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/cfg_lane_select.sv
// Aligns the addressed byte to bit 0 and keeps only the requested width.
// Bytes beyond the end of the dword come back as zero. Combinational.
module cfg_lane_select #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        byte_sel,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] lane
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep;

    // Shift the addressed byte down to lane 0.
    always_comb shifted = word >> {byte_sel, 3'b000};

    // Width mask from the access size; unknown sizes keep everything.
    always_comb begin
        case (size)
            SIZE_W'(1): keep = DATA_W'({8{1'b1}});
            SIZE_W'(2): keep = DATA_W'({16{1'b1}});
            default:    keep = '1;
        endcase
    end

    // Final lane data.
    always_comb lane = shifted & keep;
endmodule

// File: rtl/cfg_emu_responder.sv
// Top of the emulated configuration responder. Serves reads for bus 0,
// devices DEV_A and DEV_B from constant tables, tracks the one-shot
// BAR size-probe flag, flags unexpected writes and forwards every other
// access to the pass-through port. The pass-through port is assumed to
// return read data combinationally in the request cycle.
module cfg_emu_responder
    import cfg_emu_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int DEVFN_W    = 8,
    parameter int OFF_W      = 8,
    parameter int SIZE_W     = 3,
    parameter int DATA_W     = 32,
    parameter int DEV_A      = 1,
    parameter int DEV_B      = 15,
    parameter int MASK_WORDS = 8,
    parameter int HDR_BYTES  = 'h70,
    parameter int BAR_LO     = 'h10,
    parameter int BAR_HI     = 'h2C,
    parameter int CMD_OFF    = 'h04,
    parameter int CLS_OFF    = 'h0C,
    parameter int LAT_OFF    = 'h0D,
    parameter int ROM_OFF    = 'h30,
    parameter int PM_OFF     = 'h44
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               variant_sel,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    output logic               warn_pulse,
    output logic               fwd_valid,
    output logic               fwd_write,
    output logic [BUS_W-1:0]   fwd_bus,
    output logic [DEVFN_W-1:0] fwd_devfn,
    output logic [OFF_W-1:0]   fwd_off,
    output logic [SIZE_W-1:0]  fwd_size,
    output logic [DATA_W-1:0]  fwd_wdata,
    input  logic [DATA_W-1:0]  fwd_rdata
);
    localparam int TBL_WORDS = MASK_WORDS + HDR_BYTES / 4;
    localparam int IDX_W     = $clog2(TBL_WORDS + 1);

    logic              emu_hit;
    fn_id_e            fn_id;
    logic              probe_q;
    logic              bar_win;
    logic              quiet_off;
    logic              size_ok;
    logic              use_mask;
    logic [IDX_W-1:0]  norm_idx;
    logic [IDX_W-1:0]  probe_idx;
    logic [IDX_W-1:0]  rom_idx;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] lane_word;
    logic [DATA_W-1:0] emu_rdata;
    logic              rd_req;
    logic              emu_wr;

    cfg_emu_decode #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .DEV_A(DEV_A), .DEV_B(DEV_B)
    ) u_decode (
        .bus(req_bus), .devfn(req_devfn), .variant(variant_sel),
        .emu_hit(emu_hit), .fn_id(fn_id)
    );

    // Offset classification: BAR window, quiet registers, legal size.
    always_comb begin
        bar_win   = (req_off >= OFF_W'(BAR_LO)) && (req_off < OFF_W'(BAR_HI));
        quiet_off = (req_off == OFF_W'(CMD_OFF)) || (req_off == OFF_W'(CLS_OFF)) ||
                    (req_off == OFF_W'(LAT_OFF)) || (req_off == OFF_W'(ROM_OFF)) ||
                    (req_off == OFF_W'(PM_OFF));
        size_ok   = (req_size == SIZE_W'(1)) || (req_size == SIZE_W'(2)) ||
                    (req_size == SIZE_W'(4));
        rd_req    = req_valid && !req_write;
        emu_wr    = req_valid && req_write && emu_hit;
    end

    // Table index: mask area while probing, otherwise past the mask area.
    always_comb begin
        use_mask  = probe_q && bar_win;
        norm_idx  = IDX_W'(MASK_WORDS) + IDX_W'(req_off >> 2);
        probe_idx = IDX_W'(req_off >> 2) - IDX_W'(BAR_LO / 4);
        rom_idx   = use_mask ? probe_idx : norm_idx;
    end

    cfg_hdr_rom #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rom (
        .fn_id(fn_id), .variant(variant_sel), .idx(rom_idx), .word(rom_word)
    );

    cfg_lane_select #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_lane (
        .word(rom_word), .byte_sel(req_off[1:0]), .size(req_size), .lane(lane_word)
    );

    // Emulated read data with its precedence: size, range, presence.
    always_comb begin
        if (!size_ok)                          emu_rdata = '1;
        else if (req_off >= OFF_W'(HDR_BYTES)) emu_rdata = '0;
        else if (fn_id == FN_NONE)             emu_rdata = '1;
        else                                   emu_rdata = lane_word;
    end

    // Pass-through request: fields copied, valid only off the emulated slots.
    always_comb begin
        fwd_valid = req_valid && !emu_hit;
        fwd_write = req_write;
        fwd_bus   = req_bus;
        fwd_devfn = req_devfn;
        fwd_off   = req_off;
        fwd_size  = req_size;
        fwd_wdata = req_wdata;
    end

    // Probe flag: set by an all-ones BAR write, cleared by any emulated read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_q <= 1'b0;
        end else if (req_valid && emu_hit) begin
            if (req_write && bar_win && (req_wdata == '1)) probe_q <= 1'b1;
            else if (!req_write)                          probe_q <= 1'b0;
        end
    end

    // Response register: one cycle after every read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) begin
                rsp_rdata <= emu_hit ? emu_rdata : fwd_rdata;
                rsp_err   <= emu_hit && !size_ok;
            end
        end
    end

    // Warning pulse for emulated writes outside the BAR window and quiet set.
    always_ff @(posedge clk) begin
        if (!rst_n) warn_pulse <= 1'b0;
        else        warn_pulse <= emu_wr && !bar_win && !quiet_off;
    end
endmodule

// File: rtl/cfg_emu_chk.sv
// Protocol checker for the emulated configuration responder, bound to
// the top. Observes ports only; holds no state of its own.
module cfg_emu_chk #(
    parameter int DEV_A = 1,
    parameter int DEV_B = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_bus,
    input logic [7:0]  req_devfn,
    input logic [7:0]  req_off,
    input logic [2:0]  req_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        warn_pulse,
    input logic        fwd_valid
);
    logic emu_c;
    logic size_good;
    always_comb begin
        emu_c = (req_bus == 8'd0) &&
                ((req_devfn[7:3] == 5'(DEV_A)) || (req_devfn[7:3] == 5'(DEV_B)));
        size_good = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
    end

    // R1
    fwd_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !emu_c) |-> fwd_valid);

    // R1
    fwd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && emu_c) |-> !fwd_valid);

    // R2
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    no_rsp_for_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_write) |=> !rsp_valid);

    // R10
    warn_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> $past(req_valid && req_write && emu_c));

    // R11
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && emu_c && !size_good) |=>
        (rsp_err && rsp_rdata == 32'hFFFF_FFFF));

    // R6
    high_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && emu_c && size_good && req_off >= 8'h70) |=>
        (rsp_rdata == 32'd0 && !rsp_err));
endmodule

bind cfg_emu_responder cfg_emu_chk #(.DEV_A(DEV_A), .DEV_B(DEV_B)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
    .req_size(req_size), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .warn_pulse(warn_pulse), .fwd_valid(fwd_valid)
);

// File: tb/sim_cfg_emu_responder.sv
module sim_cfg_emu_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        variant_sel = 1'b0;
    logic        rsp_valid, rsp_err, warn_pulse;
    logic [31:0] rsp_rdata;
    logic        fwd_valid, fwd_write;
    logic [7:0]  fwd_bus, fwd_devfn, fwd_off;
    logic [2:0]  fwd_size;
    logic [31:0] fwd_wdata;
    logic [31:0] fwd_rdata = 32'h5A5A_0001;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_data_q[$];
    logic        exp_err_q[$];
    string       exp_tag_q[$];

    always #2.5 clk = ~clk;

    cfg_emu_responder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata), .variant_sel(variant_sel),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .warn_pulse(warn_pulse), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
        .fwd_bus(fwd_bus), .fwd_devfn(fwd_devfn), .fwd_off(fwd_off),
        .fwd_size(fwd_size), .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expectation per response, compare data and error flag.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] ed;
                logic        ee;
                string       et;
                ed = exp_data_q.pop_front();
                ee = exp_err_q.pop_front();
                et = exp_tag_q.pop_front();
                check(rsp_rdata === ed, et, rsp_rdata, ed);
                check(rsp_err === ee, {et, " err"}, 32'(rsp_err), 32'(ee));
            end
        end
    end

    // Driver: a read; pushes the expected response into the scoreboard.
    task automatic do_read(input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [7:0] off, input logic [2:0] size,
                           input logic [31:0] exp, input logic exp_err,
                           input logic exp_fwd, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bus = bus; req_devfn = devfn;
        req_off = off; req_size = size; req_wdata = 32'h0;
        #1;
        check(fwd_valid === exp_fwd, {tag, " fwd_valid"}, 32'(fwd_valid), 32'(exp_fwd));
        exp_data_q.push_back(exp);
        exp_err_q.push_back(exp_err);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Driver: a write; checks forwarding now and the warning after the edge.
    task automatic do_write(input logic [7:0] bus, input logic [7:0] devfn,
                            input logic [7:0] off, input logic [31:0] data,
                            input logic exp_warn, input logic exp_fwd,
                            input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_bus = bus; req_devfn = devfn;
        req_off = off; req_size = 3'd4; req_wdata = data;
        #1;
        check(fwd_valid === exp_fwd, {tag, " fwd_valid"}, 32'(fwd_valid), 32'(exp_fwd));
        @(negedge clk);
        check(warn_pulse === exp_warn, {tag, " warn"}, 32'(warn_pulse), 32'(exp_warn));
        req_valid = 1'b0;
    endtask

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_err === 1'b0 && warn_pulse === 1'b0,
              "R12 reset outputs", {29'b0, rsp_valid, rsp_err, warn_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: flag clear after reset, so a BAR-window read gives data
        do_read(8'd0, 8'h08, 8'h10, 3'd4, 32'h0000_C001, 1'b0, 1'b0, "R12 probe clear");

        // R3 R13 normal reads and byte lanes, variant A
        do_read(8'd0, 8'h08, 8'h00, 3'd4, 32'h1100_1D0E, 1'b0, 1'b0, "R3 dword");
        do_read(8'd0, 8'h08, 8'h02, 3'd2, 32'h0000_1100, 1'b0, 1'b0, "R3 half");
        do_read(8'd0, 8'h08, 8'h01, 3'd1, 32'h0000_001D, 1'b0, 1'b0, "R3 byte");
        do_read(8'd0, 8'h08, 8'h03, 3'd2, 32'h0000_0011, 1'b0, 1'b0, "R3 past end");
        do_read(8'd0, 8'h7C, 8'h40, 3'd4, 32'hC802_0001, 1'b0, 1'b0, "R13 usb cap");
        do_read(8'd0, 8'h78, 8'h00, 3'd4, 32'h3100_1D0E, 1'b0, 1'b0, "R13 bridge id");

        // R4 probe then R5 one-shot
        do_write(8'd0, 8'h78, 8'h14, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 probe write");
        do_read(8'd0, 8'h78, 8'h14, 3'd4, 32'hFFFF_FF01, 1'b0, 1'b0, "R4 mask read");
        do_read(8'd0, 8'h78, 8'h14, 3'd4, 32'h0000_1001, 1'b0, 1'b0, "R5 one shot");

        // R5 read outside window clears flag and returns data
        do_write(8'd0, 8'h78, 8'h14, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 probe write");
        do_read(8'd0, 8'h78, 8'h00, 3'd4, 32'h3100_1D0E, 1'b0, 1'b0, "R5 outside window");
        do_read(8'd0, 8'h78, 8'h14, 3'd4, 32'h0000_1001, 1'b0, 1'b0, "R5 cleared");

        // R5 R1 forwarded read does not clear the flag
        do_write(8'd0, 8'h78, 8'h14, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 probe write 2");
        fwd_rdata = 32'hCAFE_0123;
        do_read(8'd1, 8'h78, 8'h14, 3'd4, 32'hCAFE_0123, 1'b0, 1'b1, "R1 fwd read bus1");
        do_read(8'd0, 8'h78, 8'h14, 3'd4, 32'hFFFF_FF01, 1'b0, 1'b0, "R5 fwd keeps flag");
        fwd_rdata = 32'h0BAD_F00D;
        do_read(8'd0, 8'h10, 8'h00, 3'd4, 32'h0BAD_F00D, 1'b0, 1'b1, "R1 fwd read dev2");
        do_read(8'd0, 8'h10, 8'h00, 3'd3, 32'h0BAD_F00D, 1'b0, 1'b1, "R11 fwd no err");

        // R1 forwarded write carries its fields
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_bus = 8'd2; req_devfn = 8'h33;
        req_off = 8'h18; req_size = 3'd2; req_wdata = 32'h1357_9BDF;
        #1;
        check(fwd_valid && fwd_write && fwd_bus == 8'd2 && fwd_devfn == 8'h33 &&
              fwd_off == 8'h18 && fwd_size == 3'd2 && fwd_wdata == 32'h1357_9BDF,
              "R1 fwd fields", fwd_wdata, 32'h1357_9BDF);
        @(negedge clk);
        check(warn_pulse === 1'b0, "R10 fwd write no warn", 32'(warn_pulse), 32'h0);
        req_valid = 1'b0;

        // R9 writes discarded; non-ones BAR write leaves flag clear
        do_write(8'd0, 8'h08, 8'h10, 32'h0000_1234, 1'b0, 1'b0, "R9 bar write");
        do_read(8'd0, 8'h08, 8'h10, 3'd4, 32'h0000_C001, 1'b0, 1'b0, "R9 unchanged");
        do_write(8'd0, 8'h08, 8'h00, 32'hDEAD_BEEF, 1'b1, 1'b0, "R9 id write");
        do_read(8'd0, 8'h08, 8'h00, 3'd4, 32'h1100_1D0E, 1'b0, 1'b0, "R9 id kept");

        // R6 R7 range and unknown functions
        do_read(8'd0, 8'h08, 8'h70, 3'd4, 32'h0000_0000, 1'b0, 1'b0, "R6 high off");
        do_read(8'd0, 8'h0B, 8'h70, 3'd4, 32'h0000_0000, 1'b0, 1'b0, "R6 beats R7");
        do_read(8'd0, 8'h0B, 8'h00, 3'd4, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7 unknown fn");
        do_read(8'd0, 8'h7F, 8'h04, 3'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7 unknown fn2");

        // R8 variant selection
        do_read(8'd0, 8'h0A, 8'h00, 3'd4, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 crypto absent");
        do_read(8'd0, 8'h09, 8'h00, 3'd4, 32'h2100_1D0E, 1'b0, 1'b0, "R8 gfx A id");
        do_write(8'd0, 8'h09, 8'h10, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 gfx A probe");
        do_read(8'd0, 8'h09, 8'h10, 3'd4, 32'hFF80_0008, 1'b0, 1'b0, "R8 gfx A mask");
        variant_sel = 1'b1;
        do_read(8'd0, 8'h08, 8'h00, 3'd4, 32'h1200_1D0E, 1'b0, 1'b0, "R8 host B id");
        do_read(8'd0, 8'h0A, 8'h00, 3'd4, 32'h2300_1D0E, 1'b0, 1'b0, "R8 crypto present");
        do_read(8'd0, 8'h09, 8'h00, 3'd4, 32'h2200_1D0E, 1'b0, 1'b0, "R8 gfx B id");
        do_write(8'd0, 8'h09, 8'h10, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 gfx B probe");
        do_read(8'd0, 8'h09, 8'h10, 3'd4, 32'hFF00_0008, 1'b0, 1'b0, "R8 gfx B mask");
        variant_sel = 1'b0;

        // R10 warning offsets
        do_write(8'd0, 8'h08, 8'h04, 32'h0000_0007, 1'b0, 1'b0, "R10 cmd quiet");
        do_write(8'd0, 8'h08, 8'h0C, 32'h0000_0010, 1'b0, 1'b0, "R10 cls quiet");
        do_write(8'd0, 8'h08, 8'h0D, 32'h0000_0040, 1'b0, 1'b0, "R10 lat quiet");
        do_write(8'd0, 8'h78, 8'h30, 32'h0000_0000, 1'b0, 1'b0, "R10 rom quiet");
        do_write(8'd0, 8'h7C, 8'h44, 32'h0000_0003, 1'b0, 1'b0, "R10 pm quiet");
        do_write(8'd0, 8'h7C, 8'h45, 32'h0000_0003, 1'b1, 1'b0, "R10 near pm warns");
        do_write(8'd0, 8'h08, 8'h08, 32'h0000_0001, 1'b1, 1'b0, "R10 class warns");
        do_write(8'd0, 8'h08, 8'h2C, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10 past window warns");
        do_read(8'd0, 8'h08, 8'h10, 3'd4, 32'h0000_C001, 1'b0, 1'b0, "R4 0x2C no probe");

        // R11 illegal sizes
        do_read(8'd0, 8'h08, 8'h00, 3'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 size 3");
        do_read(8'd0, 8'h78, 8'h00, 3'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 size 0");
        do_read(8'd0, 8'h78, 8'h00, 3'd4, 32'h3100_1D0E, 1'b0, 1'b0, "R11 err clears");

        repeat (3) @(negedge clk);
        check(exp_data_q.size() == 0, "R2 missing responses",
              32'(exp_data_q.size()), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule